// File: doc/BRIEF.md
# Chainable Four-Channel Periodic Interrupt Timer

This block provides a set of periodic timers behind a small register bank. Each channel holds a programmable load value and a down-counter. Once enabled, the counter steps toward zero, and the step out of zero counts as an expiry. On an expiry the channel reloads from its load value and sets a sticky timeout flag. Each channel drives an interrupt line that goes high while its flag and its interrupt-enable bit are both set.

A channel can be chained to the channel below it. A chained channel then steps once per expiry of its predecessor, so two or more channels together form one long timer. A module-level control register can stop every channel at once. It can also hold all counters while an external debug-halt input is high.

Software uses a single-cycle register port. A write takes effect on the clock edge where the write strobe is sampled. Read data is registered and appears one cycle after the read strobe.

Top module: `chained_period_timer`

## Requirements
- R1: An enabled channel with load value L, running unchained and unhindered, sets its timeout flag once every L+1 cycles. On each expiry it reloads L into the counter.
- R2: Writing a new load value while a channel runs does not disturb the count in progress. The new value is used from the next reload on.
- R3: A write that takes the enable bit from 0 to 1 loads the current load value into the counter. Clearing and then setting enable therefore restarts the period from the load value.
- R4: When a channel's chain bit is set, the channel steps only in cycles where the next-lower channel expires. Channel 0 ignores its chain bit.
- R5: The timeout flag is bit 0 of the channel's flag register at channel offset 0xC. Writing 1 to that bit clears the flag. Writing 0 leaves it unchanged. Once set, the flag stays set until it is cleared.
- R6: `irq[n]` is high exactly while channel n's flag and its interrupt-enable bit are both set. Setting interrupt enable while the flag is already set raises the line on the next cycle.
- R7: The module control register is at offset 0x000. Its bit 1 is the module-disable bit; while it is set, no counter changes. The register resets to 0x00000006, and its bit 2 always reads as 1.
- R8: While the module control register's bit 0 (freeze) is set and `dbg_halt` is high, no counter changes. Freeze without `dbg_halt` has no effect.
- R9: Channel n's registers start at offset 0x100 + 0x10*n. The load value is at +0x0, the current count is at +0x4 and is read-only, and control is at +0x8. In the control register, bit 0 is enable, bit 1 is interrupt enable and bit 2 is chain.
- R10: If an expiry and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R11: Unmapped addresses read as zero. Reserved bits read as zero and ignore writes. The current count reads as zero while its channel is disabled.
- R12: A read strobe in one cycle places the addressed value on `reg_rdata` after that clock edge. `reg_rdata` keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Debug-halt request, honoured when freeze is set |
| irq | output | N_CH | Per-channel interrupt lines |

## Verification
Several properties are checked on every cycle. A flag that is not being cleared stays set. An expiry always leaves its flag set, even against a clear in the same cycle. An expiry with interrupt enable set raises the line. No enabled counter moves while the module is disabled, while the freeze condition holds, or while a chained channel's predecessor does not expire. The bench's scenarios are what show the exact period of L+1 cycles, the deferred use of a new load value, restart on re-enable, and the register map and read-back values. A cycle-accurate behavioural model checks these values on every clock.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int BUS_W = 32;

  // register slot inside a channel window, selected by address bits [3:2]
  localparam logic [1:0] SLOT_LOAD = 2'd0;
  localparam logic [1:0] SLOT_CUR  = 2'd1;
  localparam logic [1:0] SLOT_CTRL = 2'd2;
  localparam logic [1:0] SLOT_FLAG = 2'd3;

  // module control bit positions
  localparam int MC_FREEZE  = 0;
  localparam int MC_DISABLE = 1;

  // channel control, bit 0 = enable, bit 1 = irq enable, bit 2 = chain
  typedef struct packed {
    logic chain;
    logic ie;
    logic en;
  } ch_ctrl_t;
endpackage

// File: rtl/ptmr_regdec.sv
module ptmr_regdec #(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              mcr_hit,
  output logic [N_CH-1:0]   ch_hit,
  output logic [1:0]        slot
);
  localparam int BANK_W = ADDR_W - 8;

  logic in_bank;

  assign mcr_hit = (addr == '0);
  assign in_bank = (addr[ADDR_W-1:8] == BANK_W'(1)) && (addr[1:0] == 2'b00);
  assign slot    = addr[3:2];

  for (genvar i = 0; i < N_CH; i++) begin : g_hit
    assign ch_hit[i] = in_bank && (addr[7:4] == 4'(i));
  end
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel #(
  parameter int CNT_W = 32,
  parameter bit FIRST = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                chain_in,
  input  logic                ld_we,
  input  logic                ctl_we,
  input  logic                flg_clr,
  input  logic [CNT_W-1:0]    wdata,
  output logic                expire,
  output logic [CNT_W-1:0]    ld_q,
  output logic [CNT_W-1:0]    cnt_q,
  output ptmr_pkg::ch_ctrl_t  ctrl_q,
  output logic                flag_q,
  output logic                irq
);
  logic step;
  logic active;
  logic en_rise;

  if (FIRST) begin : g_head
    assign step = 1'b1;
  end else begin : g_link
    assign step = ctrl_q.chain ? chain_in : 1'b1;
  end

  assign active  = ctrl_q.en && run && step;
  assign expire  = active && (cnt_q == '0);
  assign en_rise = ctl_we && wdata[0] && !ctrl_q.en;
  assign irq     = flag_q && ctrl_q.ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q   <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ld_we)  ld_q   <= wdata;
      if (ctl_we) ctrl_q <= ptmr_pkg::ch_ctrl_t'(wdata[2:0]);
      if (en_rise || expire) cnt_q <= ld_q;
      else if (active)       cnt_q <= cnt_q - 1'b1;
      flag_q <= expire || (flag_q && !flg_clr);
    end
  end
endmodule

// File: rtl/chained_period_timer.sv
module chained_period_timer #(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dbg_halt,
  output logic [N_CH-1:0]   irq
);
  import ptmr_pkg::*;

  logic                       mcr_hit;
  logic [N_CH-1:0]            ch_hit;
  logic [1:0]                 slot;
  logic                       frz_q;
  logic                       mdis_q;
  logic                       run;
  logic [N_CH-1:0]            ch_exp;
  logic [N_CH-1:0]            chain_in;
  logic [N_CH-1:0]            ch_flag;
  logic [N_CH-1:0]            ch_ie;
  logic [N_CH-1:0]            ch_en;
  logic [N_CH-1:0]            ch_chain;
  logic [N_CH-1:0]            flg_clr;
  logic [N_CH-1:0][CNT_W-1:0] ch_cnt;
  logic [N_CH-1:0][CNT_W-1:0] ch_ld;
  logic [BUS_W-1:0]           rd_val;

  ptmr_regdec #(.N_CH(N_CH), .ADDR_W(ADDR_W)) dec_i (
    .addr    (reg_addr),
    .mcr_hit (mcr_hit),
    .ch_hit  (ch_hit),
    .slot    (slot)
  );

  assign run      = !mdis_q && !(frz_q && dbg_halt);
  assign chain_in = {ch_exp[N_CH-2:0], 1'b0};

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    ch_ctrl_t ctl;
    logic     sel_w;

    assign sel_w      = reg_we && ch_hit[i];
    assign flg_clr[i] = sel_w && (slot == SLOT_FLAG) && reg_wdata[0];

    ptmr_channel #(.CNT_W(CNT_W), .FIRST(i == 0)) ch_i (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .chain_in (chain_in[i]),
      .ld_we    (sel_w && (slot == SLOT_LOAD)),
      .ctl_we   (sel_w && (slot == SLOT_CTRL)),
      .flg_clr  (flg_clr[i]),
      .wdata    (reg_wdata[CNT_W-1:0]),
      .expire   (ch_exp[i]),
      .ld_q     (ch_ld[i]),
      .cnt_q    (ch_cnt[i]),
      .ctrl_q   (ctl),
      .flag_q   (ch_flag[i]),
      .irq      (irq[i])
    );

    assign ch_en[i]    = ctl.en;
    assign ch_ie[i]    = ctl.ie;
    assign ch_chain[i] = ctl.chain;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_q  <= 1'b0;
      mdis_q <= 1'b1;
    end else if (reg_we && mcr_hit) begin
      frz_q  <= reg_wdata[MC_FREEZE];
      mdis_q <= reg_wdata[MC_DISABLE];
    end
  end

  always_comb begin
    rd_val = '0;
    if (mcr_hit) rd_val = {29'b0, 1'b1, mdis_q, frz_q};
    for (int i = 0; i < N_CH; i++) begin
      if (ch_hit[i]) begin
        case (slot)
          SLOT_LOAD: rd_val = BUS_W'(ch_ld[i]);
          SLOT_CUR:  rd_val = ch_en[i] ? BUS_W'(ch_cnt[i]) : '0;
          SLOT_CTRL: rd_val = {29'b0, ch_chain[i], ch_ie[i], ch_en[i]};
          default:   rd_val = {31'b0, ch_flag[i]};
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int N_CH  = 4,
  parameter int CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic [N_CH-1:0]            irq,
  input logic [N_CH-1:0]            ch_flag,
  input logic [N_CH-1:0]            ch_ie,
  input logic [N_CH-1:0]            ch_en,
  input logic [N_CH-1:0]            ch_chain,
  input logic [N_CH-1:0]            ch_exp,
  input logic [N_CH-1:0]            flg_clr,
  input logic [N_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic                       mdis_q,
  input logic                       frz_q,
  input logic                       dbg_halt
);
  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    assert_expiry_irq_R6: assert property (@(posedge clk) disable iff (rst)
      ch_exp[i] |=> (irq[i] || !ch_ie[i]));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      ch_exp[i] |=> ch_flag[i]);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      (ch_flag[i] && !flg_clr[i]) |=> ch_flag[i]);

    assert_disable_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (mdis_q && ch_en[i]) |=> $stable(ch_cnt[i]));

    assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (frz_q && dbg_halt && ch_en[i]) |=> $stable(ch_cnt[i]));

    if (i > 0) begin : g_link
      assert_chain_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (ch_en[i] && ch_chain[i] && !ch_exp[i-1]) |=> $stable(ch_cnt[i]));
    end
  end
endmodule

bind chained_period_timer ptmr_checker #(.N_CH(N_CH), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .ch_flag  (ch_flag),
  .ch_ie    (ch_ie),
  .ch_en    (ch_en),
  .ch_chain (ch_chain),
  .ch_exp   (ch_exp),
  .flg_clr  (flg_clr),
  .ch_cnt   (ch_cnt),
  .mdis_q   (mdis_q),
  .frz_q    (frz_q),
  .dbg_halt (dbg_halt)
);

// File: tb/chained_period_timer_tb_top.sv
module chained_period_timer_tb_top;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic        dbg_halt = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chained_period_timer #(.N_CH(NC), .CNT_W(32), .ADDR_W(12)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halt(dbg_halt), .irq(irq)
  );

  // behavioural reference model, advanced on every rising edge
  bit [31:0] m_ld [NC];
  bit [31:0] m_cnt[NC];
  bit [2:0]  m_ctl[NC];
  bit        m_flag[NC];
  bit        m_frz, m_mdis;
  bit [31:0] m_rdata;

  always @(posedge clk) begin : model
    bit ex[NC];
    bit st[NC];
    bit run, hit, rise;
    bit [31:0] rv;
    int ch;
    if (rst) begin
      for (int i = 0; i < NC; i++) begin
        m_ld[i] = 0; m_cnt[i] = 0; m_ctl[i] = 0; m_flag[i] = 0;
      end
      m_frz = 0; m_mdis = 1; m_rdata = 0;
    end else begin
      run = !m_mdis && !(m_frz && dbg_halt);
      for (int i = 0; i < NC; i++) begin
        st[i] = (i > 0 && m_ctl[i][2]) ? ex[i-1] : 1'b1;
        ex[i] = m_ctl[i][0] && run && st[i] && (m_cnt[i] == 0);
      end
      if (reg_re) begin
        rv = 0;
        if (reg_addr == 0) rv = {29'b0, 1'b1, m_mdis, m_frz};
        else if (reg_addr[11:8] == 1 && reg_addr[1:0] == 0 && reg_addr[7:4] < NC) begin
          ch = int'(reg_addr[7:4]);
          case (reg_addr[3:2])
            2'd0: rv = m_ld[ch];
            2'd1: rv = m_ctl[ch][0] ? m_cnt[ch] : 0;
            2'd2: rv = {29'b0, m_ctl[ch]};
            default: rv = {31'b0, m_flag[ch]};
          endcase
        end
        m_rdata = rv;
      end
      for (int i = 0; i < NC; i++) begin
        hit  = reg_we && reg_addr[11:8] == 1 && reg_addr[1:0] == 0 && int'(reg_addr[7:4]) == i;
        rise = hit && reg_addr[3:2] == 2 && reg_wdata[0] && !m_ctl[i][0];
        if (rise || ex[i]) m_cnt[i] = m_ld[i];
        else if (m_ctl[i][0] && run && st[i]) m_cnt[i] = m_cnt[i] - 1;
        m_flag[i] = ex[i] || (m_flag[i] && !(hit && reg_addr[3:2] == 3 && reg_wdata[0]));
        if (hit && reg_addr[3:2] == 0) m_ld[i] = reg_wdata;
        if (hit && reg_addr[3:2] == 2) m_ctl[i] = reg_wdata[2:0];
      end
      if (reg_we && reg_addr == 0) begin
        m_frz = reg_wdata[0]; m_mdis = reg_wdata[1];
      end
    end
  end

  // per-cycle comparison away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int i = 0; i < NC; i++) begin
        n_chk++;
        if (irq[i] !== (m_flag[i] && m_ctl[i][1])) begin
          n_fail++;
          $display("FAIL R6 irq[%0d] actual %b expected %b at %0t", i, irq[i], m_flag[i] && m_ctl[i][1], $time);
        end
      end
      n_chk++;
      if (reg_rdata !== m_rdata) begin
        n_fail++;
        $display("FAIL R12 rdata actual %h expected %h at %0t", reg_rdata, m_rdata, $time);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w;
    int k;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(12'h000, v); chk(v, 32'h6, "R7 module control reset value");
    chk(32'(irq), 0, "R6 irq low after reset");
    rd(12'h108, v); chk(v, 0, "R9 control resets to zero");
    rd(12'h080, v); chk(v, 0, "R11 unmapped read");
    rd(12'h004, v); chk(v, 0, "R11 unmapped read near module control");

    wr(12'h100, 5);
    rd(12'h104, v); chk(v, 0, "R11 current value of disabled channel");
    rd(12'h100, v); chk(v, 5, "R9 load value read back");

    // period of L+1
    wr(12'h000, 0);
    wr(12'h100, 3);
    wr(12'h108, 3);
    k = 0;
    while (irq[0] == 1'b0 && k < 20) begin @(negedge clk); k++; end
    chk(k, 4, "R1 cycles from enable to first expiry");
    wr(12'h108, 0);
    rd(12'h10C, v); chk(v, 1, "R1 flag set by expiry");
    wr(12'h10C, 0);
    rd(12'h10C, v); chk(v, 1, "R5 writing zero keeps flag");
    wr(12'h10C, 1);
    rd(12'h10C, v); chk(v, 0, "R5 write one clears flag");

    // interrupt enable with pending flag
    wr(12'h100, 1);
    wr(12'h108, 1);
    idle(6);
    wr(12'h108, 0);
    chk(32'(irq[0]), 0, "R6 irq low with ie clear");
    wr(12'h108, 2);
    chk(32'(irq[0]), 1, "R6 irq rises when ie set over pending flag");
    wr(12'h10C, 1);
    chk(32'(irq[0]), 0, "R6 irq drops with flag");
    wr(12'h108, 0);

    // restart and deferred load
    wr(12'h100, 7);
    wr(12'h108, 1);
    rd(12'h104, v); chk(v, 7, "R3 enable loads the load value");
    wr(12'h100, 2);
    rd(12'h104, v); chk(v, 5, "R2 load write does not restart count");
    wr(12'h108, 0);
    wr(12'h108, 1);
    rd(12'h104, v); chk(v, 2, "R3 re-enable restarts from new load");
    idle(12);
    wr(12'h108, 0);
    wr(12'h10C, 1);

    // chaining
    wr(12'h100, 1);
    wr(12'h110, 2);
    wr(12'h118, 5);
    wr(12'h108, 5);
    idle(20);
    rd(12'h10C, v); chk(v, 1, "R4 channel 0 ignores its chain bit");
    rd(12'h11C, v); chk(v, 1, "R4 chained channel expires");
    wr(12'h108, 0);
    rd(12'h114, v);
    idle(10);
    rd(12'h114, w); chk(w, v, "R4 chained channel waits for predecessor");

    // module disable
    wr(12'h108, 1);
    idle(3);
    wr(12'h000, 2);
    rd(12'h104, v);
    idle(5);
    rd(12'h104, w); chk(w, v, "R7 module disable holds counters");
    rd(12'h000, v); chk(v, 32'h6, "R7 module control read back");
    wr(12'h000, 0);

    // freeze
    wr(12'h000, 1);
    idle(3);
    dbg_halt = 1'b1;
    rd(12'h104, v);
    idle(5);
    rd(12'h104, w); chk(w, v, "R8 freeze with debug halt holds counters");
    dbg_halt = 1'b0;
    idle(4);
    wr(12'h000, 0);
    dbg_halt = 1'b1;
    idle(6);
    dbg_halt = 1'b0;

    // expiry against clear in the same cycle
    wr(12'h108, 0);
    wr(12'h100, 0);
    wr(12'h108, 1);
    wr(12'h10C, 1);
    rd(12'h10C, v); chk(v, 1, "R10 expiry wins over clear");
    wr(12'h108, 0);

    // reserved bits
    wr(12'h128, 32'hFFFF_FFFF);
    rd(12'h128, v); chk(v, 7, "R11 reserved control bits read zero");
    wr(12'h128, 0);
    wr(12'h000, 32'hFFFF_FFF8);
    rd(12'h000, v); chk(v, 32'h4, "R11 reserved module control bits ignored");
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule